// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address. It does this by walking a two-level translation structure that is kept in ordinary memory. A requester hands it a virtual address, a write flag, a user-mode flag and the page frame number of the root directory. The walker then fetches one directory entry and one leaf entry, one after the other, over a single-word memory port. It checks each entry for presence and for permission. On success it returns the physical address. On failure it returns a fault cause code instead.

When a translation succeeds, the walker records usage in the leaf entry. Every successful access sets the accessed bit, and a successful write also sets the dirty bit. The leaf entry is written back to memory only when one of these two bits changes. Directory entries use the same bit layout as leaf entries. Their frame field names the next table page instead of a data frame.

The block handles one request at a time. It accepts a request only when idle, and it holds the result until the requester takes it.

Top module: `ptw_walker`

## Requirements
- R1: During and right after reset, req_ready is 1, and rsp_valid and mem_req are 0.
- R2: The directory entry is read at word address {req_root, vaddr[31:22], 2'b00}. The leaf entry is read at {dir[31:12], vaddr[21:12], 2'b00}. A successful translation returns rsp_paddr = {leaf[31:12], vaddr[11:0]} with rsp_cause 0.
- R3: A directory entry with bit 0 (present) clear ends the walk with cause 1, whatever its other bits hold. No leaf read takes place.
- R4: A leaf entry with bit 0 clear ends the walk with cause 2, whatever its other bits hold, and there is no write-back.
- R5: A write request fails with cause 3 if bit 1 (writable) is clear in the directory entry or in the leaf entry. A directory-level failure happens before any leaf read.
- R6: A user request fails with cause 4 if bit 2 (user) is clear in either entry. A supervisor request ignores bit 2. Within one entry, the write check takes priority over the user check.
- R7: A successful read sets bit 5 of the leaf entry. A successful write sets bits 5 and 6. The updated entry is written back once, to the leaf entry's own address, and the other bits are kept.
- R8: There is no memory write when bits 5 and 6 already hold their target values, and none on any fault. The walker never clears bit 5 or bit 6.
- R9: Only the leaf entry used for the walk is updated. Another leaf entry that maps the same frame keeps its value.
- R10: Once rsp_valid is 1, it stays 1 with rsp_paddr and rsp_cause held stable until rsp_ready is 1. Every fault returns rsp_paddr 0. req_ready is 1 only while no walk is in progress.
- R11: mem_req stays 1, with mem_addr, mem_we and mem_wdata held stable, until mem_ack. A walk makes one memory access when a directory entry faults, two when the walk ends at the leaf, and three when a write-back is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| req_root | input | 20 | Page frame number of the root directory |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_cause | output | 3 | 0 ok, 1 directory absent, 2 leaf absent, 3 write protect, 4 user protect |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Entry value read |

## Verification
The bench builds the walker with its default geometry: 32-bit virtual addresses and entries, 10-bit indices and a 12-bit page offset. These values are what make both ends of the index range reachable with real addresses. Directory index 1023, leaf index 0 and a root placed anywhere in memory can all be tried, and the frame and offset splice into the physical address can be checked bit for bit. The memory model in the bench answers with a latency that changes between runs, so that the request-hold rules are tested with both immediate and delayed acknowledges.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

   // entry flag positions (shared by directory and leaf entries)
   localparam int FLAG_PRESENT = 0;
   localparam int FLAG_WRITE   = 1;
   localparam int FLAG_USER    = 2;
   localparam int FLAG_USED    = 5;
   localparam int FLAG_MODIF   = 6;
   localparam int FLAG_CHK_W   = 3;

   typedef enum logic [2:0] {
      CAUSE_OK          = 3'd0,
      CAUSE_DIR_ABSENT  = 3'd1,
      CAUSE_LEAF_ABSENT = 3'd2,
      CAUSE_WRITE_PROT  = 3'd3,
      CAUSE_USER_PROT   = 3'd4
   } ptw_cause_e;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_RD_DIR,
      WS_RD_LEAF,
      WS_WR_LEAF,
      WS_RESP
   } ptw_state_e;

endpackage

// File: rtl/ptw_entry_chk.sv
`timescale 1ns/1ps
module ptw_entry_chk
   import ptw_pkg::*;
#(
   parameter ptw_cause_e ABSENT_CODE = CAUSE_DIR_ABSENT
) (
   input  logic [FLAG_CHK_W-1:0] flags,
   input  logic                  is_write,
   input  logic                  is_user,
   output ptw_cause_e            cause
);

   // absent beats write, write beats user
   always_comb begin
      if (!flags[FLAG_PRESENT])
         cause = ABSENT_CODE;
      else if (is_write && !flags[FLAG_WRITE])
         cause = CAUSE_WRITE_PROT;
      else if (is_user && !flags[FLAG_USER])
         cause = CAUSE_USER_PROT;
      else
         cause = CAUSE_OK;
   end

endmodule

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
   parameter int ENTRY_W = 32,
   parameter int IDX_W   = 10,
   parameter int OFS_W   = 12
) (
   input  logic [ENTRY_W-OFS_W-1:0] base_pfn,
   input  logic [2*IDX_W-1:0]       vidx,
   input  logic                     leaf_lvl,
   output logic [ENTRY_W-1:0]       entry_addr
);

   localparam int ENT_LOG2 = $clog2(ENTRY_W / 8);

   logic [IDX_W-1:0] idx;

   always_comb begin
      idx        = leaf_lvl ? vidx[IDX_W-1:0] : vidx[2*IDX_W-1:IDX_W];
      entry_addr = {base_pfn, idx, {ENT_LOG2{1'b0}}};
   end

endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int ENTRY_W = 32,
   parameter int IDX_W   = 10,
   parameter int OFS_W   = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic                     req_write,
   input  logic                     req_user,
   input  logic [ENTRY_W-OFS_W-1:0] req_root,
   output logic                     rsp_valid,
   input  logic                     rsp_ready,
   output logic [ENTRY_W-1:0]       rsp_paddr,
   output logic [2:0]               rsp_cause,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ENTRY_W-1:0]       mem_addr,
   output logic [ENTRY_W-1:0]       mem_wdata,
   input  logic                     mem_ack,
   input  logic [ENTRY_W-1:0]       mem_rdata
);

   localparam int ENT_LOG2 = $clog2(ENTRY_W / 8);
   localparam int PFN_W    = ENTRY_W - OFS_W;
   localparam int LEVELS   = 2;

   generate
      if (VA_W != LEVELS * IDX_W + OFS_W) begin : g_bad_split
         $error("ptw_walker: VA_W must equal two indices plus the offset");
      end
      if (IDX_W + ENT_LOG2 != OFS_W) begin : g_bad_table
         $error("ptw_walker: one table must fill exactly one page");
      end
      if (OFS_W <= FLAG_MODIF) begin : g_bad_flags
         $error("ptw_walker: offset too narrow for the flag bits");
      end
   endgenerate

   ptw_state_e           state;
   logic [VA_W-1:0]      va_q;
   logic                 wr_q;
   logic                 usr_q;
   logic [PFN_W-1:0]     base_q;
   logic [ENTRY_W-1:0]   leaf_q;
   logic [ENTRY_W-1:0]   paddr_q;
   ptw_cause_e           cause_q;
   ptw_cause_e           lvl_cause [LEVELS];
   logic [ENTRY_W-1:0]   set_mask;
   logic [ENTRY_W-1:0]   leaf_upd;

   // one checker per table level; they differ only in their absent code
   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      ptw_entry_chk #(
         .ABSENT_CODE(lv == 0 ? CAUSE_DIR_ABSENT : CAUSE_LEAF_ABSENT)
      ) u_chk (
         .flags   (mem_rdata[FLAG_CHK_W-1:0]),
         .is_write(wr_q),
         .is_user (usr_q),
         .cause   (lvl_cause[lv])
      );
   end

   ptw_addr_gen #(
      .ENTRY_W(ENTRY_W),
      .IDX_W  (IDX_W),
      .OFS_W  (OFS_W)
   ) u_addr (
      .base_pfn  (base_q),
      .vidx      (va_q[VA_W-1:OFS_W]),
      .leaf_lvl  (state != WS_RD_DIR),
      .entry_addr(mem_addr)
   );

   always_comb begin
      set_mask             = '0;
      set_mask[FLAG_USED]  = 1'b1;
      set_mask[FLAG_MODIF] = wr_q;
      leaf_upd             = mem_rdata | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         base_q  <= '0;
         leaf_q  <= '0;
         paddr_q <= '0;
         cause_q <= CAUSE_OK;
      end else begin
         unique case (state)
            WS_IDLE: if (req_valid) begin
               va_q   <= req_vaddr;
               wr_q   <= req_write;
               usr_q  <= req_user;
               base_q <= req_root;
               state  <= WS_RD_DIR;
            end
            WS_RD_DIR: if (mem_ack) begin
               if (lvl_cause[0] != CAUSE_OK) begin
                  cause_q <= lvl_cause[0];
                  paddr_q <= '0;
                  state   <= WS_RESP;
               end else begin
                  base_q <= mem_rdata[ENTRY_W-1:OFS_W];
                  state  <= WS_RD_LEAF;
               end
            end
            WS_RD_LEAF: if (mem_ack) begin
               cause_q <= lvl_cause[1];
               if (lvl_cause[1] != CAUSE_OK) begin
                  paddr_q <= '0;
                  state   <= WS_RESP;
               end else begin
                  paddr_q <= {mem_rdata[ENTRY_W-1:OFS_W], va_q[OFS_W-1:0]};
                  leaf_q  <= leaf_upd;
                  state   <= (leaf_upd != mem_rdata) ? WS_WR_LEAF : WS_RESP;
               end
            end
            WS_WR_LEAF: if (mem_ack) state <= WS_RESP;
            WS_RESP:    if (rsp_ready) state <= WS_IDLE;
            default:    state <= WS_IDLE;
         endcase
      end
   end

   assign req_ready = (state == WS_IDLE);
   assign rsp_valid = (state == WS_RESP);
   assign rsp_paddr = paddr_q;
   assign rsp_cause = cause_q;
   assign mem_req   = (state == WS_RD_DIR) || (state == WS_RD_LEAF) || (state == WS_WR_LEAF);
   assign mem_we    = (state == WS_WR_LEAF);
   assign mem_wdata = leaf_q;

endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk
   import ptw_pkg::*;
#(
   parameter int ENTRY_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic               rsp_ready,
   input logic [ENTRY_W-1:0] rsp_paddr,
   input logic [2:0]         rsp_cause,
   input logic               mem_req,
   input logic               mem_we,
   input logic [ENTRY_W-1:0] mem_addr,
   input logic [ENTRY_W-1:0] mem_wdata,
   input logic               mem_ack
);

   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause));

   // R10
   fault_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_cause != 3'd0 |-> rsp_paddr == '0);

   // R10
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && (rsp_valid || mem_req)));

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R7
   wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[FLAG_USED] && mem_wdata[FLAG_PRESENT]);

   // R2
   cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_cause <= 3'd4);

endmodule

bind ptw_walker ptw_walker_chk #(.ENTRY_W(ENTRY_W)) u_walker_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready),
   .rsp_paddr(rsp_paddr),
   .rsp_cause(rsp_cause),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ack  (mem_ack)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [19:0] req_root = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_cause;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2 clk = ~clk;

   ptw_walker dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .req_root(req_root),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_cause(rsp_cause),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   logic [31:0] mem [logic [31:0]];
   int n_cmp = 0;
   int n_bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int mem_lat = 0;
   int wait_cnt = 0;
   logic [31:0] last_wa = '0;
   logic [31:0] last_wd = '0;

   localparam logic [19:0] ROOT = 20'h00010;

   function automatic logic [31:0] peek(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // memory responder with adjustable latency
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (wait_cnt < mem_lat) begin
               wait_cnt++;
            end else begin
               wait_cnt = 0;
               if (mem_we) begin
                  mem[mem_addr] = mem_wdata;
                  wr_cnt++;
                  last_wa = mem_addr;
                  last_wd = mem_wdata;
               end else begin
                  mem_rdata = peek(mem_addr);
                  rd_cnt++;
               end
               mem_ack = 1'b1;
            end
         end
      end
   end

   // behavioural reference of one walk
   task automatic model(input logic [31:0] va, input logic [19:0] root,
                        input bit w, input bit u,
                        output logic [31:0] c, output logic [31:0] pa,
                        output int nrd, output bit dowr,
                        output logic [31:0] wa, output logic [31:0] wd);
      logic [31:0] da, de, la, le, ne;
      da = {root, 12'h000} + (va >> 22) * 4;
      de = peek(da);
      nrd = 1; dowr = 0; pa = 0; wa = 0; wd = 0;
      if (!de[0])               c = 1;
      else if (w && !de[1])     c = 3;
      else if (u && !de[2])     c = 4;
      else begin
         la = (de & 32'hFFFF_F000) + ((va >> 12) & 32'h3FF) * 4;
         le = peek(la);
         nrd = 2;
         if (!le[0])            c = 2;
         else if (w && !le[1])  c = 3;
         else if (u && !le[2])  c = 4;
         else begin
            c  = 0;
            pa = (le & 32'hFFFF_F000) | (va & 32'hFFF);
            ne = le | 32'h20 | (w ? 32'h40 : 32'h0);
            if (ne != le) begin
               dowr = 1; wa = la; wd = ne;
            end
         end
      end
   endtask

   task automatic xlate(string tag, logic [31:0] va, bit w, bit u, int hold);
      logic [31:0] ec, ep, ewa, ewd, pc, pp;
      int enrd, r0, w0;
      bit ewr;
      model(va, ROOT, w, u, ec, ep, enrd, ewr, ewa, ewd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      r0 = rd_cnt; w0 = wr_cnt;
      req_vaddr = va; req_write = w; req_user = u; req_root = ROOT;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      for (int i = 0; i < hold; i++) begin
         pc = {29'd0, rsp_cause};
         pp = rsp_paddr;
         @(negedge clk);
         check({tag, " R10 held valid"}, {31'd0, rsp_valid}, 32'd1);
         check({tag, " R10 held cause"}, {29'd0, rsp_cause}, pc);
         check({tag, " R10 held paddr"}, rsp_paddr, pp);
      end
      check({tag, " cause"}, {29'd0, rsp_cause}, ec);
      check({tag, " paddr"}, rsp_paddr, ep);
      check({tag, " R11 reads"}, rd_cnt - r0, enrd);
      check({tag, " R8 writes"}, wr_cnt - w0, ewr ? 1 : 0);
      if (ewr) begin
         check({tag, " R7 wb addr"}, last_wa, ewa);
         check({tag, " R7 wb data"}, last_wd, ewd);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check({tag, " R10 idle after"}, {31'd0, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] keep;
      // directory: entry 1 -> table at 0x20000 (P W U)
      mem[32'h0001_0004] = 32'h0002_0007;
      mem[32'h0002_000C] = 32'h0055_5007;   // idx 3 rw user
      mem[32'h0002_0010] = 32'h0066_6005;   // idx 4 read-only user
      mem[32'h0002_0014] = 32'h0077_7003;   // idx 5 supervisor rw
      mem[32'h0002_0018] = 32'hABCD_E0E6;   // idx 6 absent, junk
      mem[32'h0002_001C] = 32'h0055_5007;   // idx 7 aliases idx 3
      mem[32'h0001_0008] = 32'hFFFF_F0FE;   // dir 2 absent, junk
      mem[32'h0001_000C] = 32'h0003_0005;   // dir 3 read-only
      mem[32'h0003_0000] = 32'h0088_8007;
      mem[32'h0001_0010] = 32'h0004_0003;   // dir 4 supervisor
      mem[32'h0004_0000] = 32'h0099_9007;
      mem[32'h0001_0014] = 32'h0005_0001;   // dir 5 present only
      mem[32'h0001_0FFC] = 32'h0006_0007;   // dir 1023
      mem[32'h0006_0004] = 32'h00AB_C007;

      repeat (3) @(negedge clk);
      check("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
      check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-reset req_ready", {31'd0, req_ready}, 32'd1);

      for (int lat = 0; lat < 3; lat += 2) begin
         mem_lat = lat;
         xlate("R2 R11 user read", 32'h0040_3123, 1'b0, 1'b1, 0);
         check("R7 accessed set", peek(32'h0002_000C), 32'h0055_5027);
      end
      xlate("R8 repeat read no wb", 32'h0040_3ABC, 1'b0, 1'b1, 0);
      xlate("R7 user write dirty", 32'h0040_3FFF, 1'b1, 1'b1, 0);
      check("R7 dirty set", peek(32'h0002_000C), 32'h0055_5067);
      xlate("R8 write again no wb", 32'h0040_3000, 1'b1, 1'b0, 0);

      mem_lat = 1;
      xlate("R5 leaf read-only write", 32'h0040_4010, 1'b1, 1'b1, 0);
      xlate("R5 leaf read-only read ok", 32'h0040_4010, 1'b0, 1'b1, 0);
      xlate("R6 user on supervisor leaf", 32'h0040_5444, 1'b0, 1'b1, 0);
      xlate("R6 supervisor write ok", 32'h0040_5444, 1'b1, 1'b0, 0);
      keep = peek(32'h0002_0018);
      xlate("R4 leaf absent", 32'h0040_6000, 1'b1, 1'b1, 0);
      check("R8 absent leaf untouched", peek(32'h0002_0018), keep);
      xlate("R3 dir absent", 32'h0080_0123, 1'b0, 1'b0, 0);
      xlate("R5 dir read-only write", 32'h00C0_0004, 1'b1, 1'b0, 0);
      xlate("R5 dir read-only read ok", 32'h00C0_0004, 1'b0, 1'b1, 0);
      xlate("R6 dir supervisor user read", 32'h0100_0ABC, 1'b0, 1'b1, 0);
      xlate("R6 dir supervisor read ok", 32'h0100_0ABC, 1'b0, 1'b0, 0);
      xlate("R6 write before user priority", 32'h0140_0000, 1'b1, 1'b1, 0);
      xlate("R2 top directory index", 32'hFFC0_1F0E, 1'b0, 1'b0, 0);

      mem_lat = 0;
      mem[32'h0002_001C] = 32'h0055_5007;
      mem[32'h0002_000C] = 32'h0055_5007;
      xlate("R9 write via alias", 32'h0040_7055, 1'b1, 1'b1, 0);
      check("R9 alias updated", peek(32'h0002_001C), 32'h0055_5067);
      check("R9 other alias untouched", peek(32'h0002_000C), 32'h0055_5007);
      xlate("R10 backpressure", 32'h0040_3321, 1'b0, 1'b1, 4);
      xlate("R10 fault backpressure", 32'h0080_0000, 1'b0, 1'b1, 3);

      summary();
      $finish;
   end

endmodule